// File: doc/BRIEF.md
# Atomic Snooping Bus Arbiter with Memory Responder

This block owns a shared broadcast bus used by a group of caching nodes (4, 8 or 16 of them). A node raises a one-cycle request carrying a query kind (a shared read or an exclusive read) and an address. Requests join a first-come queue, and the query at the head of that queue is placed on the bus for one cycle, tagged with the requester's node number, so every snooper sees it and can tell whether it issued it. The bus then stays locked until exactly one DATA message closes the transaction.

A snooping cache that holds the line may answer by raising its data strobe during the lock. Otherwise a built-in memory model answers after a fixed latency. An early cache answer cancels the memory answer. Two counters record how many transactions were closed by a cache and how many by memory.

The control is a four-state machine. In IDLE the bus is free. In QUERY the granted query is broadcast. In WAIT the bus is locked and waits for DATA. In DATA the closing message is broadcast. The transitions are: IDLE to QUERY when the queue holds a request, QUERY to WAIT always, WAIT to DATA on a cache strobe or when the memory timer expires, DATA to QUERY when the queue holds a request, and DATA to IDLE otherwise.

Top module: `snoop_bus_arbiter`

## Requirements
- R1: After reset, bus_valid and bus_busy are 0 and both counters are 0.
- R2: A request sampled at a clock edge while the bus is idle and the queue is empty appears on the bus two cycles after the cycle in which it was driven. It is held for exactly one cycle with bus_msg set to the query code (1 = shared read, 2 = exclusive read), bus_node set to the requester and bus_addr set to its address.
- R3: From the query cycle until the closing DATA, bus_busy is 1 and no other message appears on the bus. Every query is followed by exactly one DATA (bus_msg = 3).
- R4: If no cache answers, DATA appears exactly MEM_LAT cycles after the query cycle, with bus_src_mem = 1, bus_node equal to the requester and bus_addr equal to the query address, and mem_count increments by one.
- R5: A cache strobe sampled k cycles after the query cycle, with 1 <= k <= MEM_LAT-1, produces DATA in the following cycle, with bus_src_mem = 0 and bus_node equal to the lowest strobing node. c2c_count increments by one and no memory DATA follows.
- R6: A cache strobe sampled in the query cycle, or while the bus is not locked, has no effect.
- R7: Requests arriving in different cycles are granted in arrival order, whatever their node numbers.
- R8: Requests arriving in the same cycle are granted in ascending node number.
- R9: After a DATA cycle, the next queued query appears in the very next cycle.
- R10: A request from a node that still has an entry waiting in the queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NODES | One-cycle request strobe per node |
| req_excl | input | NODES | Per node: 1 = exclusive read, 0 = shared read |
| req_addr | input | NODES*ADDR_W | Per-node request address, node i in slice i |
| snoop_data | input | NODES | Per-node strobe: this cache supplies the data |
| bus_valid | output | 1 | A message is on the bus this cycle |
| bus_msg | output | 2 | 0 none, 1 shared read, 2 exclusive read, 3 DATA |
| bus_node | output | NODE_W | Requester for a query or memory DATA; supplying cache for cache DATA |
| bus_addr | output | ADDR_W | Address of the current transaction |
| bus_src_mem | output | 1 | DATA came from memory |
| bus_busy | output | 1 | Bus is locked by an open query |
| c2c_count | output | CNT_W | Transactions closed by a cache |
| mem_count | output | CNT_W | Transactions closed by memory |

## Verification
The hardest cases to reach are the edges of the cache-answer window: a strobe in the query cycle itself, one in the last cycle before memory would answer, and one after memory has already answered. The stimulus finds the query cycle by watching the bus, then sweeps the strobe delay across 0, 1, a middle value, MEM_LAT-1 and MEM_LAT. First-come ordering, and the dropping of a repeated request, are reached by issuing staggered requests, with node numbers out of order, while an earlier transaction holds the lock.

// File: rtl/snoop_bus_pkg.sv
package snoop_bus_pkg;

    typedef enum logic [1:0] {
        MSG_NONE = 2'd0,
        MSG_GETS = 2'd1,
        MSG_GETM = 2'd2,
        MSG_DATA = 2'd3
    } bus_msg_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_QUERY,
        S_WAIT,
        S_DATA
    } bus_state_t;

endpackage

// File: rtl/arb_queue.sv
module arb_queue #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          pop,
    output logic [N-1:0]  accept,
    output logic [IW-1:0] head,
    output logic          empty
);
    localparam int CW = $clog2(N + 1);

    logic [IW-1:0] slot_q [N];
    logic [IW-1:0] slot_d [N];
    logic [CW-1:0] cnt_q, cnt_d;
    logic [N-1:0]  pend_q, pend_d;

    assign accept = req & ~pend_q;
    assign head   = slot_q[0];
    assign empty  = (cnt_q == '0);

    always_comb begin
        slot_d = slot_q;
        cnt_d  = cnt_q;
        pend_d = pend_q;
        if (pop && cnt_q != '0) begin
            pend_d[slot_q[0]] = 1'b0;
            for (int i = 0; i < N - 1; i++) slot_d[i] = slot_q[i+1];
            slot_d[N-1] = '0;
            cnt_d = cnt_q - 1'b1;
        end
        // ascending node order sets the order of same-cycle arrivals
        for (int i = 0; i < N; i++) begin
            if (accept[i]) begin
                slot_d[cnt_d[IW-1:0]] = IW'(i);
                pend_d[i] = 1'b1;
                cnt_d = cnt_d + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= '0;
            for (int i = 0; i < N; i++) slot_q[i] <= '0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
            slot_q <= slot_d;
        end
    end
endmodule

// File: rtl/mem_timer.sv
module mem_timer #(
    parameter int LAT = 100,
    parameter int TW  = $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (start) cnt_q <= '0;
        else if (run)   cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == TW'(LAT - 1));
endmodule

// File: rtl/src_pick.sv
module src_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end

    assign any = |hits;
endmodule

// File: rtl/snoop_bus_arbiter.sv
module snoop_bus_arbiter
    import snoop_bus_pkg::*;
#(
    parameter int NODES   = 4,
    parameter int ADDR_W  = 16,
    parameter int MEM_LAT = 100,
    parameter int CNT_W   = 16,
    parameter int NODE_W  = $clog2(NODES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NODES-1:0]        req_valid,
    input  logic [NODES-1:0]        req_excl,
    input  logic [NODES*ADDR_W-1:0] req_addr,
    input  logic [NODES-1:0]        snoop_data,
    output logic                    bus_valid,
    output logic [1:0]              bus_msg,
    output logic [NODE_W-1:0]       bus_node,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic                    bus_src_mem,
    output logic                    bus_busy,
    output logic [CNT_W-1:0]        c2c_count,
    output logic [CNT_W-1:0]        mem_count
);
    bus_state_t state_q, state_d;

    logic [NODES-1:0]  accept;
    logic [NODE_W-1:0] head;
    logic              q_empty;
    logic              grant;
    logic              expire;
    logic              hit_any;
    logic [NODE_W-1:0] hit_idx;
    logic              cache_win, mem_fire;

    logic              node_excl_q [NODES];
    logic [ADDR_W-1:0] node_addr_q [NODES];

    logic [NODE_W-1:0] cur_node_q, src_node_q;
    logic              cur_excl_q, src_mem_q;
    logic [ADDR_W-1:0] cur_addr_q;

    assign grant     = (state_q == S_IDLE || state_q == S_DATA) && !q_empty;
    assign cache_win = (state_q == S_WAIT) && hit_any;
    assign mem_fire  = (state_q == S_WAIT) && !hit_any && expire;

    arb_queue #(.N(NODES), .IW(NODE_W)) u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_valid),
        .pop    (grant),
        .accept (accept),
        .head   (head),
        .empty  (q_empty)
    );

    mem_timer #(.LAT(MEM_LAT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (grant),
        .run    (state_q == S_QUERY || state_q == S_WAIT),
        .expire (expire)
    );

    src_pick #(.N(NODES), .IW(NODE_W)) u_pick (
        .hits (snoop_data),
        .any  (hit_any),
        .idx  (hit_idx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (!q_empty) state_d = S_QUERY;
            S_QUERY: state_d = S_WAIT;
            S_WAIT:  if (cache_win || mem_fire) state_d = S_DATA;
            S_DATA:  state_d = q_empty ? S_IDLE : S_QUERY;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and transaction datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cur_node_q <= '0;
            cur_excl_q <= 1'b0;
            cur_addr_q <= '0;
            src_node_q <= '0;
            src_mem_q  <= 1'b0;
            c2c_count  <= '0;
            mem_count  <= '0;
            for (int i = 0; i < NODES; i++) begin
                node_excl_q[i] <= 1'b0;
                node_addr_q[i] <= '0;
            end
        end else begin
            state_q <= state_d;
            for (int i = 0; i < NODES; i++) begin
                if (accept[i]) begin
                    node_excl_q[i] <= req_excl[i];
                    node_addr_q[i] <= req_addr[i*ADDR_W +: ADDR_W];
                end
            end
            if (grant) begin
                cur_node_q <= head;
                cur_excl_q <= node_excl_q[head];
                cur_addr_q <= node_addr_q[head];
            end
            if (cache_win) begin
                src_node_q <= hit_idx;
                src_mem_q  <= 1'b0;
                c2c_count  <= c2c_count + 1'b1;
            end else if (mem_fire) begin
                src_node_q <= cur_node_q;
                src_mem_q  <= 1'b1;
                mem_count  <= mem_count + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        bus_valid   = 1'b0;
        bus_msg     = MSG_NONE;
        bus_node    = cur_node_q;
        bus_src_mem = 1'b0;
        bus_busy    = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_QUERY: begin
                bus_valid = 1'b1;
                bus_msg   = cur_excl_q ? MSG_GETM : MSG_GETS;
                bus_busy  = 1'b1;
            end
            S_WAIT: bus_busy = 1'b1;
            S_DATA: begin
                bus_valid   = 1'b1;
                bus_msg     = MSG_DATA;
                bus_node    = src_node_q;
                bus_src_mem = src_mem_q;
            end
            default: ;
        endcase
    end

    assign bus_addr = cur_addr_q;
endmodule

// File: rtl/snoop_bus_chk.sv
module snoop_bus_chk #(
    parameter int MEM_LAT = 100,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic [1:0]       bus_msg,
    input logic             bus_src_mem,
    input logic             bus_busy,
    input logic [CNT_W-1:0] c2c_count,
    input logic [CNT_W-1:0] mem_count
);
    localparam int LW = $clog2(MEM_LAT + 2);

    logic          is_query, is_data;
    logic [LW-1:0] lat_q;

    assign is_query = bus_valid && (bus_msg == 2'd1 || bus_msg == 2'd2);
    assign is_data  = bus_valid && (bus_msg == 2'd3);

    always_ff @(posedge clk) begin
        if (!rst_n)                       lat_q <= '0;
        else if (is_query)                lat_q <= LW'(1);
        else if (lat_q != LW'(MEM_LAT + 1)) lat_q <= lat_q + 1'b1;
    end

    // R3
    lock_after_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_query |=> (bus_busy && !bus_valid));

    // R3
    no_query_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> !is_query);

    // R3
    data_follows_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_data |-> $past(bus_busy));

    // R4
    mem_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && bus_src_mem) |-> (lat_q == LW'(MEM_LAT)));

    // R4
    mem_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && bus_src_mem) |-> (mem_count == $past(mem_count) + 1'b1));

    // R5
    cache_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && !bus_src_mem) |-> (lat_q >= LW'(2) && lat_q <= LW'(MEM_LAT)));

    // R5
    c2c_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && !bus_src_mem) |-> (c2c_count == $past(c2c_count) + 1'b1));
endmodule

bind snoop_bus_arbiter snoop_bus_chk #(.MEM_LAT(MEM_LAT), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_msg     (bus_msg),
    .bus_src_mem (bus_src_mem),
    .bus_busy    (bus_busy),
    .c2c_count   (c2c_count),
    .mem_count   (mem_count)
);

// File: tb/test_snoop_bus_arbiter.sv
module test_snoop_bus_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int AW  = 16;
    localparam int LAT = 100;
    localparam int CW  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N-1:0]    req_excl = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N-1:0]    snoop_data = '0;
    logic            bus_valid;
    logic [1:0]      bus_msg;
    logic [1:0]      bus_node;
    logic [AW-1:0]   bus_addr;
    logic            bus_src_mem;
    logic            bus_busy;
    logic [CW-1:0]   c2c_count;
    logic [CW-1:0]   mem_count;

    snoop_bus_arbiter #(.NODES(N), .ADDR_W(AW), .MEM_LAT(LAT), .CNT_W(CW)) i_snoop_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_excl(req_excl),
        .req_addr(req_addr), .snoop_data(snoop_data), .bus_valid(bus_valid),
        .bus_msg(bus_msg), .bus_node(bus_node), .bus_addr(bus_addr),
        .bus_src_mem(bus_src_mem), .bus_busy(bus_busy),
        .c2c_count(c2c_count), .mem_count(mem_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int ev_msg [64];
    int ev_node[64];
    int ev_addr[64];
    int ev_mem [64];
    int ev_cyc [64];
    int nev = 0;

    always @(negedge clk) begin
        if (rst_n && bus_valid && nev < 64) begin
            ev_msg[nev]  = int'(bus_msg);
            ev_node[nev] = int'(bus_node);
            ev_addr[nev] = int'(bus_addr);
            ev_mem[nev]  = int'(bus_src_mem);
            ev_cyc[nev]  = cyc;
            nev = nev + 1;
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // drive a one-cycle request burst; returns the cycle in which it was driven
    task automatic pulse_req(input logic [N-1:0] mask, input logic [N-1:0] excl,
                             input int base, output int t);
        @(negedge clk);
        t = cyc;
        req_valid = mask;
        req_excl  = excl;
        for (int i = 0; i < N; i++) req_addr[i*AW +: AW] = AW'(base + i);
        @(negedge clk);
        req_valid = '0;
    endtask

    task automatic wait_query(output int q);
        do @(negedge clk); while (!(bus_valid && (bus_msg == 2'd1 || bus_msg == 2'd2)));
        q = cyc;
    endtask

    task automatic wait_ev(input int target);
        while (nev < target) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int t, q, b, c2c0, mem0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_eq("R1 bus_valid", int'(bus_valid), 0);
        chk_eq("R1 bus_busy", int'(bus_busy), 0);
        chk_eq("R1 c2c_count", int'(c2c_count), 0);
        chk_eq("R1 mem_count", int'(mem_count), 0);

        // R2 R4 single exclusive read answered by memory
        b = nev;
        pulse_req(4'b0100, 4'b0100, 16'h1230, t);
        wait_query(q);
        chk_eq("R2 query cycle", q, t + 2);
        repeat (10) @(negedge clk);
        chk_eq("R3 busy during lock", int'(bus_busy), 1);
        chk_eq("R3 nothing on bus during lock", int'(bus_valid), 0);
        wait_ev(b + 2);
        chk_eq("R2 query msg", ev_msg[b], 2);
        chk_eq("R2 query node", ev_node[b], 2);
        chk_eq("R2 query addr", ev_addr[b], 16'h1232);
        chk_eq("R2 one-cycle query", ev_cyc[b + 1] - ev_cyc[b], LAT);
        chk_eq("R4 data msg", ev_msg[b + 1], 3);
        chk_eq("R4 data from memory", ev_mem[b + 1], 1);
        chk_eq("R4 latency", ev_cyc[b + 1] - ev_cyc[b], LAT);
        chk_eq("R4 data node", ev_node[b + 1], 2);
        chk_eq("R4 data addr", ev_addr[b + 1], 16'h1232);
        @(negedge clk);
        chk_eq("R4 mem_count", int'(mem_count), 1);

        // R8 R9 all nodes in the same cycle, shared reads
        b = nev;
        pulse_req(4'b1111, 4'b0000, 16'h0400, t);
        wait_ev(b + 8);
        for (int i = 0; i < N; i++) begin
            chk_eq("R8 grant order", ev_node[b + 2*i], i);
            chk_eq("R8 query msg", ev_msg[b + 2*i], 1);
            chk_eq("R8 query addr", ev_addr[b + 2*i], 16'h0400 + i);
            chk_eq("R4 memory latency", ev_cyc[b + 2*i + 1] - ev_cyc[b + 2*i], LAT);
            if (i > 0)
                chk_eq("R9 back-to-back grant", ev_cyc[b + 2*i] - ev_cyc[b + 2*i - 1], 1);
        end
        repeat (3) @(negedge clk);
        chk_eq("R4 mem_count after burst", int'(mem_count), 5);

        // R5 R6 sweep of the cache strobe delay, node 3 supplies
        foreach (ev_msg[k0]) begin
            int k;
            if (k0 > 4) break;
            k = (k0 == 0) ? 0 : (k0 == 1) ? 1 : (k0 == 2) ? 50 : (k0 == 3) ? LAT - 1 : LAT;
            b = nev;
            c2c0 = int'(c2c_count);
            mem0 = int'(mem_count);
            pulse_req(4'b0010, 4'b0010, 16'h0800, t);
            wait_query(q);
            repeat (k) @(negedge clk);
            snoop_data = 4'b1000;
            @(negedge clk);
            snoop_data = '0;
            wait_ev(b + 2);
            repeat (2) @(negedge clk);
            if (k >= 1 && k <= LAT - 1) begin
                chk_eq("R5 cache data cycle", ev_cyc[b + 1] - q, k + 1);
                chk_eq("R5 cache source flag", ev_mem[b + 1], 0);
                chk_eq("R5 cache source node", ev_node[b + 1], 3);
                chk_eq("R5 c2c_count", int'(c2c_count), c2c0 + 1);
                chk_eq("R5 memory cancelled", int'(mem_count), mem0);
            end else begin
                chk_eq("R6 strobe ignored, memory latency", ev_cyc[b + 1] - q, LAT);
                chk_eq("R6 strobe ignored, source flag", ev_mem[b + 1], 1);
                chk_eq("R6 c2c_count unchanged", int'(c2c_count), c2c0);
            end
            chk_eq("R3 single data per query", nev, b + 2);
        end

        // R5 two caches strobe together, lowest node wins
        b = nev;
        pulse_req(4'b0001, 4'b0000, 16'h0900, t);
        wait_query(q);
        repeat (5) @(negedge clk);
        snoop_data = 4'b1010;
        @(negedge clk);
        snoop_data = '0;
        wait_ev(b + 2);
        chk_eq("R5 lowest supplier", ev_node[b + 1], 1);
        chk_eq("R5 multi-strobe cycle", ev_cyc[b + 1] - q, 6);

        // R6 strobe while the bus is idle has no effect
        c2c0 = int'(c2c_count);
        b = nev;
        repeat (5) @(negedge clk);
        snoop_data = 4'b0100;
        @(negedge clk);
        snoop_data = '0;
        repeat (3) @(negedge clk);
        chk_eq("R6 idle strobe no message", nev, b);
        chk_eq("R6 idle strobe no count", int'(c2c_count), c2c0);

        // R7 R10 staggered arrivals while locked, with a repeat from node 1
        b = nev;
        pulse_req(4'b0001, 4'b0000, 16'h0a00, t);
        wait_query(q);
        pulse_req(4'b1000, 4'b0000, 16'h0b00, t);
        repeat (3) @(negedge clk);
        pulse_req(4'b0010, 4'b0010, 16'h0c00, t);
        repeat (3) @(negedge clk);
        pulse_req(4'b0010, 4'b0000, 16'h0d00, t);
        repeat (3) @(negedge clk);
        pulse_req(4'b0100, 4'b0000, 16'h0e00, t);
        wait_ev(b + 8);
        chk_eq("R7 first grant", ev_node[b], 0);
        chk_eq("R7 second grant", ev_node[b + 2], 3);
        chk_eq("R7 third grant", ev_node[b + 4], 1);
        chk_eq("R10 kept first request kind", ev_msg[b + 4], 2);
        chk_eq("R10 kept first request addr", ev_addr[b + 4], 16'h0c01);
        chk_eq("R7 fourth grant", ev_node[b + 6], 2);
        repeat (LAT + 20) @(negedge clk);
        chk_eq("R10 repeat dropped", nev, b + 8);
        chk_eq("R3 bus released", int'(bus_busy), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule